// File: doc/BRIEF.md
# Host Bus Interface Controller for a TDM Crosspoint Switch

This block lets a host processor reach a time-division switch core as a memory-mapped peripheral. It watches two active-low chip selects, a set of active-high cascade address lines and active-low read and write strobes. A single control/data line changes meaning with the direction of the access. On a write it tells an operand byte from an opcode byte. On a read it picks which of two output registers reaches the bus. A valid opcode becomes a command record handed to the core over a valid/ready stream. The core returns words for the two output registers over a second valid/ready stream.

The block also runs the initialization sequence, which is aligned to the frame. A request seen on the initialization pin is acted on only at the first timeslot of a frame, marked by the frame pulse. From that point initialization covers whole frames. While it runs, the core is told to clear its connection memory and disable its PCM outputs, the host data drivers stay off, and every register in this block returns to zero.

Stream rules: `cmd_valid` stays high with stable fields until a cycle with `cmd_ready` high. The block holds one command, and an opcode that arrives while a command is still waiting is dropped. `rsp_ready` is low while a host read of this device is in progress and while initialization runs. A response offered in those cycles waits until `rsp_ready` returns high.

Top module: `hbi_ctrl`

## Requirements
- R1: An access is accepted only when `cs1_n` and `cs2_n` are both low and `casc_addr` equals the `DEV_ID` parameter. Any other access changes no state and does not drive the bus.
- R2: For a write with `cd_sel` low, `bus_din` as sampled in the last clock cycle before `wr_n` rises is stored as the operand byte.
- R3: For a write with `cd_sel` high, the opcode byte is split into an opcode in bits [2:0] and a modifier in bits [7:3]. Opcodes 0 to 5 issue a command on `cmd_op`/`cmd_mod`, with `cmd_arg` set to the stored operand. Opcodes 6 and 7 are ignored.
- R4: `cmd_valid` and its fields hold until a cycle with `cmd_ready` high. An opcode that arrives while a command is waiting is dropped, but operand writes still update the operand byte.
- R5: `bus_oe` is high only while the device is selected, `rd_n` is low and no initialization runs. With `bus_oe` high, `bus_dout` shows output register 1 when `cd_sel` is low and output register 2 when it is high. With `bus_oe` low, `bus_dout` is zero.
- R6: A response word is stored when `rsp_valid` and `rsp_ready` are both high: in output register 1 when `rsp_sel` is 0, and in output register 2 when it is 1. `rsp_ready` is low during a selected read, so the word the host is reading stays stable.
- R7: `init_busy` changes only at a clock edge where `frame_sync` is high. At that edge it becomes 1 if `init_req_n` is low there, or if `init_req_n` fell at any time since the previous frame pulse. After system reset, initialization runs through the first complete frame.
- R8: While `init_busy` is high: `pcm_en` is low, writes are ignored, `cmd_valid` is cleared, `rsp_ready` is low, and the operand byte and both output registers are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low system reset |
| frame_sync | input | 1 | One-cycle pulse at the first timeslot of each frame |
| init_req_n | input | 1 | Active-low initialization request from the host side |
| cs1_n | input | 1 | Chip select one, active low |
| cs2_n | input | 1 | Chip select two, active low |
| casc_addr | input | CASC_W | Cascade address, compared with DEV_ID |
| cd_sel | input | 1 | Write: 0 operand / 1 opcode; read: 0 register 1 / 1 register 2 |
| wr_n | input | 1 | Write strobe, active low, captured on its rising edge |
| rd_n | input | 1 | Read strobe, active low |
| bus_din | input | DATA_W | Host write data |
| bus_dout | output | DATA_W | Host read data, zero when not driven |
| bus_oe | output | 1 | Host data driver enable |
| cmd_valid | output | 1 | Command stream valid |
| cmd_ready | input | 1 | Command stream ready from core |
| cmd_op | output | OP_W | Decoded opcode |
| cmd_mod | output | DATA_W-OP_W | Opcode modifier bits |
| cmd_arg | output | DATA_W | Operand byte for the command |
| rsp_valid | input | 1 | Response stream valid from core |
| rsp_ready | output | 1 | Response stream ready |
| rsp_sel | input | 1 | Target output register (0 = register 1, 1 = register 2) |
| rsp_data | input | DATA_W | Response word |
| init_busy | output | 1 | Initialization running; core clears connection memory |
| pcm_en | output | 1 | Permission for the core's PCM output drivers |

## Verification
Random writes mix full selection with cases where one chip select is high or the cascade address is wrong. Comparing the command stream with a reference model separates a correct address decode from one that checks only part of the select terms. Random readiness on the command stream, plus operand writes sent while a command is waiting, separates a command that is dropped from one that is overwritten. Reads of both registers, both with and without an active read holding off a response, show whether the register choice follows `cd_sel` and whether the hold-off works. Three initialization patterns are used: a short request pulse in mid-frame, a request held across two frame pulses, and the state just after reset. Together they show alignment to frame edges, a full-frame length whatever the pulse width, and the extra frame when the request is held.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

  // Number of opcodes the command decoder accepts; codes at or above are dropped.
  localparam int unsigned HBI_NUM_OPS  = 6;
  // Output registers reachable by host reads.
  localparam int unsigned HBI_NUM_OREG = 2;

  typedef enum logic [2:0] {
    OP_LINK      = 3'd0,
    OP_UNLINK    = 3'd1,
    OP_SEND_MSG  = 3'd2,
    OP_GRAB_MSG  = 3'd3,
    OP_PEEK_MAP  = 3'd4,
    OP_PEEK_CH0  = 3'd5
  } hbi_op_e;

  function automatic logic op_is_legal(input logic [2:0] code);
    return 32'(code) < HBI_NUM_OPS;
  endfunction

endpackage

// File: rtl/hbi_decode.sv
module hbi_decode #(
  parameter int DW     = 8,
  parameter int CW     = 4,
  parameter int DEV_ID = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_busy,
  input  logic          cs1_n,
  input  logic          cs2_n,
  input  logic [CW-1:0] casc_addr,
  input  logic          cd_sel,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic [DW-1:0] bus_din,
  output logic          wr_evt,
  output logic          wr_cd,
  output logic [DW-1:0] wr_data,
  output logic          rd_active,
  output logic          rd_cd
);

  localparam logic [CW-1:0] ID_BITS = DEV_ID[CW-1:0];

  logic          hit;
  logic          wr_q;
  logic          lat_hit;
  logic          lat_cd;
  logic [DW-1:0] lat_data;

  // Device is addressed only with both selects low and a cascade match (R1).
  assign hit = ~cs1_n & ~cs2_n & (casc_addr == ID_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b1;
      lat_hit  <= 1'b0;
      lat_cd   <= 1'b0;
      lat_data <= '0;
    end else begin
      wr_q <= wr_n;
      // Track bus state while the strobe is low; the last low cycle wins (R2).
      if (!wr_n) begin
        lat_hit  <= hit;
        lat_cd   <= cd_sel;
        lat_data <= bus_din;
      end
    end
  end

  // Rising edge of the write strobe closes the access.
  assign wr_evt    = wr_n & ~wr_q & lat_hit & ~init_busy;
  assign wr_cd     = lat_cd;
  assign wr_data   = lat_data;
  assign rd_active = hit & ~rd_n;
  assign rd_cd     = cd_sel;

endmodule

// File: rtl/hbi_cmd.sv
module hbi_cmd
  import hbi_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OPW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_busy,
  input  logic              wr_evt,
  input  logic              wr_cd,
  input  logic [DW-1:0]     wr_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [OPW-1:0]    cmd_op,
  output logic [DW-OPW-1:0] cmd_mod,
  output logic [DW-1:0]     cmd_arg
);

  localparam int MW = DW - OPW;

  logic [DW-1:0]  operand_q;
  logic [OPW-1:0] code;
  logic           code_ok;
  logic           slot_free;

  assign code      = wr_data[OPW-1:0];
  assign code_ok   = op_is_legal(code[2:0]) && (OPW == 3 || code[OPW-1:0] < OPW'(HBI_NUM_OPS));
  assign slot_free = ~cmd_valid | cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      operand_q <= '0;
      cmd_valid <= 1'b0;
      cmd_op    <= '0;
      cmd_mod   <= '0;
      cmd_arg   <= '0;
    end else if (init_busy) begin
      // Initialization wipes pending work and the operand (R8).
      operand_q <= '0;
      cmd_valid <= 1'b0;
    end else begin
      if (wr_evt && !wr_cd) operand_q <= wr_data;      // R2
      if (cmd_valid && cmd_ready) cmd_valid <= 1'b0;   // R4 handshake
      if (wr_evt && wr_cd && code_ok && slot_free) begin // R3, R4 drop when busy
        cmd_valid <= 1'b1;
        cmd_op    <= code;
        cmd_mod   <= wr_data[DW-1 -: MW];
        cmd_arg   <= operand_q;
      end
    end
  end

  a_r4_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n || init_busy)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_mod) && $stable(cmd_arg));

  a_r3_legal_op: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> 32'(cmd_op) < HBI_NUM_OPS);

  a_r8_init_drops_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |=> !cmd_valid);

endmodule

// File: rtl/hbi_rdport.sv
module hbi_rdport
  import hbi_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_busy,
  input  logic          rd_active,
  input  logic          rd_cd,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic          rsp_sel,
  input  logic [DW-1:0] rsp_data,
  output logic          bus_oe,
  output logic [DW-1:0] bus_dout
);

  logic [DW-1:0] oreg [HBI_NUM_OREG];
  logic          take;

  // Freeze both registers during a selected read and during init (R6, R8).
  assign rsp_ready = ~rd_active & ~init_busy;
  assign take      = rsp_valid & rsp_ready;

  for (genvar g = 0; g < HBI_NUM_OREG; g++) begin : g_oreg
    logic [DW-1:0] val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          val_q <= '0;
      else if (init_busy)                  val_q <= '0;
      else if (take && (32'(rsp_sel) == g)) val_q <= rsp_data;
    end
    assign oreg[g] = val_q;
  end

  // Drivers off unless selected, reading and not initializing (R5).
  assign bus_oe   = rd_active & ~init_busy;
  assign bus_dout = bus_oe ? oreg[rd_cd] : '0;

  a_r6_hold_in_read: assert property (@(posedge clk) disable iff (!rst_n || init_busy)
    rd_active && $past(rd_active) && !$past(init_busy) |-> $stable(oreg[0]) && $stable(oreg[1]));

endmodule

// File: rtl/hbi_init.sv
module hbi_init (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_sync,
  input  logic init_req_n,
  output logic init_busy,
  output logic pcm_en
);

  logic req_q;
  logic pend_q;
  logic fell;

  assign fell = req_q & ~init_req_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= 1'b1;
      pend_q    <= 1'b1;   // system reset asks for one full frame of init
      init_busy <= 1'b1;
    end else begin
      req_q <= init_req_n;
      if (frame_sync) begin
        // Strobe point: a caught pulse or a still-low pin arms one frame (R7).
        init_busy <= pend_q | fell | ~init_req_n;
        pend_q    <= 1'b0;
      end else begin
        pend_q <= pend_q | fell;
      end
    end
  end

  assign pcm_en = ~init_busy;

  a_r7_frame_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync |=> $stable(init_busy));

  a_r7_low_at_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync && !init_req_n |=> init_busy);

endmodule

// File: rtl/hbi_ctrl.sv
module hbi_ctrl #(
  parameter int DATA_W = 8,
  parameter int OP_W   = 3,
  parameter int CASC_W = 4,
  parameter int DEV_ID = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_sync,
  input  logic                   init_req_n,
  input  logic                   cs1_n,
  input  logic                   cs2_n,
  input  logic [CASC_W-1:0]      casc_addr,
  input  logic                   cd_sel,
  input  logic                   wr_n,
  input  logic                   rd_n,
  input  logic [DATA_W-1:0]      bus_din,
  output logic [DATA_W-1:0]      bus_dout,
  output logic                   bus_oe,
  output logic                   cmd_valid,
  input  logic                   cmd_ready,
  output logic [OP_W-1:0]        cmd_op,
  output logic [DATA_W-OP_W-1:0] cmd_mod,
  output logic [DATA_W-1:0]      cmd_arg,
  input  logic                   rsp_valid,
  output logic                   rsp_ready,
  input  logic                   rsp_sel,
  input  logic [DATA_W-1:0]      rsp_data,
  output logic                   init_busy,
  output logic                   pcm_en
);

  logic              wr_evt;
  logic              wr_cd;
  logic [DATA_W-1:0] wr_data;
  logic              rd_active;
  logic              rd_cd;

  hbi_init u_init (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_sync (frame_sync),
    .init_req_n (init_req_n),
    .init_busy  (init_busy),
    .pcm_en     (pcm_en)
  );

  hbi_decode #(.DW(DATA_W), .CW(CASC_W), .DEV_ID(DEV_ID)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_busy (init_busy),
    .cs1_n     (cs1_n),
    .cs2_n     (cs2_n),
    .casc_addr (casc_addr),
    .cd_sel    (cd_sel),
    .wr_n      (wr_n),
    .rd_n      (rd_n),
    .bus_din   (bus_din),
    .wr_evt    (wr_evt),
    .wr_cd     (wr_cd),
    .wr_data   (wr_data),
    .rd_active (rd_active),
    .rd_cd     (rd_cd)
  );

  hbi_cmd #(.DW(DATA_W), .OPW(OP_W)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_busy (init_busy),
    .wr_evt    (wr_evt),
    .wr_cd     (wr_cd),
    .wr_data   (wr_data),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_mod   (cmd_mod),
    .cmd_arg   (cmd_arg)
  );

  hbi_rdport #(.DW(DATA_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_busy (init_busy),
    .rd_active (rd_active),
    .rd_cd     (rd_cd),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_sel   (rsp_sel),
    .rsp_data  (rsp_data),
    .bus_oe    (bus_oe),
    .bus_dout  (bus_dout)
  );

  a_r1_miss_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (cs1_n || cs2_n) |-> !bus_oe);

endmodule

// File: tb/tb_hbi_ctrl.sv
module tb_hbi_ctrl;

  localparam int ID    = 10;
  localparam int FRAME = 64;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       frame_sync = 0;
  logic       init_req_n = 1;
  logic       cs1_n = 1, cs2_n = 1;
  logic [3:0] casc_addr = 0;
  logic       cd_sel = 0, wr_n = 1, rd_n = 1;
  logic [7:0] bus_din = 0;
  logic [7:0] bus_dout;
  logic       bus_oe, cmd_valid;
  logic       cmd_ready = 0;
  logic [2:0] cmd_op;
  logic [4:0] cmd_mod;
  logic [7:0] cmd_arg;
  logic       rsp_valid = 0, rsp_sel = 0;
  logic [7:0] rsp_data = 0;
  logic       rsp_ready, init_busy, pcm_en;

  int tests = 0, fails = 0;
  int fcnt = 0;

  // Reference model
  logic [7:0] m_data = 0;
  logic       m_valid = 0;
  logic [2:0] m_op = 0;
  logic [4:0] m_mod = 0;
  logic [7:0] m_arg = 0;
  logic [7:0] m_or [2] = '{8'h00, 8'h00};

  hbi_ctrl #(.DEV_ID(ID)) dut (.*);

  always #10 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      fcnt = (fcnt == FRAME - 1) ? 0 : fcnt + 1;
      frame_sync = (fcnt == 0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic is_hit(input logic c1, input logic c2, input logic [3:0] ca);
    return !c1 && !c2 && (ca == 4'(ID));
  endfunction

  function automatic logic legal(input logic [7:0] b);
    return b[2:0] < 3'd6;
  endfunction

  task automatic model_write(input logic h, input logic cdv, input logic [7:0] d);
    if (!h) return;
    if (!cdv) m_data = d;
    else if (legal(d) && !m_valid) begin
      m_valid = 1; m_op = d[2:0]; m_mod = d[7:3]; m_arg = m_data;
    end
  endtask

  task automatic bus_write(input logic c1, input logic c2, input logic [3:0] ca,
                           input logic cdv, input logic [7:0] d);
    @(negedge clk);
    cs1_n = c1; cs2_n = c2; casc_addr = ca; cd_sel = cdv; bus_din = d; wr_n = 0;
    @(negedge clk);
    @(negedge clk); wr_n = 1;
    @(negedge clk); cs1_n = 1; cs2_n = 1; bus_din = 8'hxx;
    #1;
  endtask

  task automatic bus_read(input logic c1, input logic c2, input logic [3:0] ca,
                          input logic cdv, output logic oe, output logic [7:0] q);
    @(negedge clk);
    cs1_n = c1; cs2_n = c2; casc_addr = ca; cd_sel = cdv; rd_n = 0;
    #1; oe = bus_oe; q = bus_dout;
    @(negedge clk); rd_n = 1; cs1_n = 1; cs2_n = 1;
  endtask

  task automatic core_rsp(input logic s, input logic [7:0] d);
    @(negedge clk); rsp_valid = 1; rsp_sel = s; rsp_data = d;
    @(negedge clk); rsp_valid = 0;
    m_or[s] = d;
  endtask

  task automatic pulse_ready();
    @(negedge clk); cmd_ready = 1;
    @(negedge clk); cmd_ready = 0;
    m_valid = 0;
    #1;
  endtask

  task automatic wait_fs();
    do @(posedge clk); while (frame_sync !== 1'b1);
    @(negedge clk); #1;
  endtask

  task automatic chk_cmd(input string req);
    chk(req, cmd_valid, m_valid);
    if (m_valid) begin
      chk(req, cmd_op, m_op);
      chk(req, cmd_mod, m_mod);
      chk(req, cmd_arg, m_arg);
    end
  endtask

  initial begin
    logic oe;
    logic [7:0] q;
    int unused_seed;
    unused_seed = $urandom(32'h1C0FFEE);

    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    // R7: init runs right after system reset
    chk("R7 reset busy", init_busy, 1);
    chk("R8 reset pcm_en", pcm_en, 0);
    chk("R8 reset cmd_valid", cmd_valid, 0);
    bus_read(0, 0, 4'(ID), 0, oe, q);
    chk("R8 no drive in init", oe, 0);
    wait_fs();
    chk("R7 first full frame", init_busy, 1);
    wait_fs();
    chk("R7 init ends", init_busy, 0);
    chk("R8 pcm_en after init", pcm_en, 1);

    // R2 / R3 directed
    bus_write(0, 0, 4'(ID), 0, 8'hA5); model_write(1, 0, 8'hA5);
    bus_write(0, 0, 4'(ID), 1, {5'h13, 3'd2}); model_write(1, 1, {5'h13, 3'd2});
    chk_cmd("R3 issue op2");
    // R4: operand updates, opcode dropped while waiting
    bus_write(0, 0, 4'(ID), 0, 8'h77); model_write(1, 0, 8'h77);
    bus_write(0, 0, 4'(ID), 1, {5'h01, 3'd1}); model_write(1, 1, {5'h01, 3'd1});
    chk_cmd("R4 dropped while pending");
    chk("R4 op held", cmd_op, 2);
    pulse_ready();
    chk("R4 released", cmd_valid, 0);
    bus_write(0, 0, 4'(ID), 1, {5'h02, 3'd1}); model_write(1, 1, {5'h02, 3'd1});
    chk("R2 new operand used", cmd_arg, 8'h77);
    pulse_ready();
    // R3: codes 6 and 7 ignored
    bus_write(0, 0, 4'(ID), 1, 8'h06);
    chk("R3 code6 ignored", cmd_valid, 0);
    bus_write(0, 0, 4'(ID), 1, 8'hFF);
    chk("R3 code7 ignored", cmd_valid, 0);
    // R1: misses leave the operand alone
    bus_write(1, 0, 4'(ID), 0, 8'h11);
    bus_write(0, 1, 4'(ID), 0, 8'h22);
    bus_write(0, 0, 4'(ID ^ 1), 0, 8'h33);
    bus_write(0, 0, 4'(ID), 1, 8'h00); model_write(1, 1, 8'h00);
    chk("R1 miss writes ignored", cmd_arg, 8'h77);
    pulse_ready();

    // R5 / R6 read path
    core_rsp(0, 8'h5A);
    core_rsp(1, 8'hC3);
    bus_read(0, 0, 4'(ID), 0, oe, q);
    chk("R5 oe", oe, 1); chk("R5 reg1", q, 8'h5A);
    bus_read(0, 0, 4'(ID), 1, oe, q);
    chk("R5 reg2", q, 8'hC3);
    bus_read(0, 0, 4'(ID ^ 4), 1, oe, q);
    chk("R1 read miss oe", oe, 0); chk("R5 dout zero", q, 0);
    // R6: response held off during read
    @(negedge clk); cs1_n = 0; cs2_n = 0; casc_addr = 4'(ID); cd_sel = 0; rd_n = 0;
    @(negedge clk); rsp_valid = 1; rsp_sel = 0; rsp_data = 8'h99;
    #1; chk("R6 ready low in read", rsp_ready, 0);
    @(negedge clk); #1; chk("R6 data stable", bus_dout, 8'h5A);
    rd_n = 1; cs1_n = 1; #1;
    chk("R6 ready back", rsp_ready, 1);
    @(negedge clk); rsp_valid = 0; m_or[0] = 8'h99;
    bus_read(0, 0, 4'(ID), 0, oe, q);
    chk("R6 late accept", q, 8'h99);

    // Random mix
    for (int i = 0; i < 80; i++) begin
      logic c1, c2, cdv, rdsel;
      logic [3:0] ca;
      logic [7:0] d;
      int kind;
      c1 = ($urandom % 5) == 0;
      c2 = ($urandom % 5) == 0;
      ca = ($urandom % 2) ? 4'(ID) : 4'($urandom);
      cdv = $urandom % 2;
      d = 8'($urandom);
      kind = $urandom % 4;
      if (kind == 0) begin
        rdsel = $urandom % 2;
        core_rsp(rdsel, 8'($urandom));
        bus_read(c1, c2, ca, rdsel, oe, q);
        chk("R5 random oe", oe, is_hit(c1, c2, ca));
        chk("R5 random data", q, is_hit(c1, c2, ca) ? m_or[rdsel] : 8'h00);
      end else begin
        bus_write(c1, c2, ca, cdv, d);
        model_write(is_hit(c1, c2, ca), cdv, d);
        chk_cmd("R3 random cmd");
        if (($urandom % 3) == 0) begin
          pulse_ready();
          chk("R4 random release", cmd_valid, 0);
        end
      end
    end
    if (m_valid) pulse_ready();

    // R7 / R8: short pulse mid-frame
    bus_write(0, 0, 4'(ID), 0, 8'h3C);
    core_rsp(1, 8'hE1);
    wait_fs();
    repeat (10) @(negedge clk);
    init_req_n = 0;
    repeat (3) @(negedge clk);
    init_req_n = 1; #1;
    chk("R7 waits for frame", init_busy, 0);
    wait_fs();
    chk("R7 pulse starts init", init_busy, 1);
    chk("R8 pcm off", pcm_en, 0);
    chk("R8 rsp_ready off", rsp_ready, 0);
    bus_write(0, 0, 4'(ID), 1, 8'h03);
    chk("R8 write ignored", cmd_valid, 0);
    bus_read(0, 0, 4'(ID), 1, oe, q);
    chk("R8 no drive", oe, 0);
    wait_fs();
    chk("R7 one frame only", init_busy, 0);
    bus_read(0, 0, 4'(ID), 1, oe, q);
    chk("R8 reg2 cleared", q, 8'h00);
    bus_write(0, 0, 4'(ID), 1, 8'h04);
    chk("R8 operand cleared", cmd_arg, 8'h00);
    pulse_ready();

    // R7: held across two strobes extends by a frame
    repeat (20) @(negedge clk);
    init_req_n = 0;
    wait_fs();
    chk("R7 held start", init_busy, 1);
    wait_fs();
    chk("R7 extended", init_busy, 1);
    repeat (5) @(negedge clk);
    init_req_n = 1;
    wait_fs();
    chk("R7 extension ends", init_busy, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule